// File: doc/BRIEF.md
# Masked Eight-Column Block Write Engine

This block models the block-write path of a video memory on a single system clock. A row cycle begins when the active-low row strobe falls. At that edge the engine captures the row address and the command. It then decides how bit masking will work for the rest of the row cycle. Each later fall of the column strobe inside that row cycle is one page cycle. A page cycle writes a preloaded 16-bit colour value into an aligned group of eight adjacent columns in one step.

The 16 data lines sampled at the column-strobe fall do not carry data. They form a byte-granular enable map over the eight columns of the group. The bit mask can come from one of three places: nothing, a value latched from the data bus at the row-strobe fall, or a sticky mask register that stays in force until a column-before-row refresh cycle clears it. Masking is applied as a read-modify-write on the internal array.

A combinational read port exposes any array word, so the array contents can be checked.

Top module: `blkw_top`

## Requirements
- R1: Reset clears the colour register, the mask register and the persistent-mask flag. A full-enable, unmasked block write made after reset therefore stores 0x0000.
- R2: The command is sampled at the row-strobe fall, with this encoding: 2'b00 = block-write row cycle, 2'b01 = load colour, 2'b10 = load mask, 2'b11 = no operation. Load colour copies the data bus into the colour register. Column strobes inside a row cycle whose command is not 2'b00 write nothing.
- R3: If write-enable is high at a block-write row-strobe fall, no bit mask applies during that row cycle, and every enabled byte takes the colour value.
- R4: If write-enable is low at a block-write row-strobe fall and the persistent flag is clear, the data bus is latched as the bit mask for that row cycle only. A bit whose mask bit is 1 takes the colour bit. A bit whose mask bit is 0 keeps its stored value.
- R5: A load-mask command (2'b10) stores the data bus in the mask register and sets the persistent flag. After that, write-enable low at a block-write row-strobe fall selects the mask register, and the data bus at that edge is ignored.
- R6: A row-strobe fall while the column strobe is already low is a refresh cycle. It clears the persistent flag and performs no writes. Later masked row cycles then latch the data bus again.
- R7: Column address bits 8..3 select the group of eight columns, and bits 2..0 are ignored.
- R8: At each column-strobe fall, data bit i (i = 0..7) enables the low byte of column group_base+i, and data bit 8+i enables the high byte of the same column. A 0 leaves that byte unchanged.
- R9: Several page cycles may occur within one row cycle, and each one applies its own enable pattern and column address.
- R10: The row address is captured at the row-strobe fall. Changes on the row address input later in the row cycle do not redirect the writes.
- R11: rdData shows the array word at row rdRow, column rdCol, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobeN | input | 1 | Active-low row strobe |
| colStrobeN | input | 1 | Active-low column strobe |
| writeEnN | input | 1 | Active-low write enable, sampled at row-strobe fall |
| cmd | input | 2 | Row-cycle command, sampled at row-strobe fall |
| dataIn | input | 16 | Colour/mask value at row fall, enable map at column fall |
| rowAddr | input | ROW_W | Row address |
| colAddr | input | 9 | Column address; bits 8..3 select the group |
| rdRow | input | ROW_W | Read-port row |
| rdCol | input | 9 | Read-port column |
| rdData | output | 16 | Read-port word |

## Verification
A wrong mask mode, a stale colour register or a misrouted enable bit only becomes visible as stored words that differ bit by bit from the expected read-modify-write result. The read port shows that difference in the cycle right after the page cycle commits. A wrong persistent flag or a mis-captured row stays hidden until a later row cycle uses it. For that reason, each scenario reads back both the target group and its untouched neighbours and the other row.

// File: rtl/blkw_pkg.sv
package blkw_pkg;

  typedef enum logic [1:0] {
    CMD_BLOCK   = 2'b00,
    CMD_LDCOLOR = 2'b01,
    CMD_LDMASK  = 2'b10,
    CMD_NOP     = 2'b11
  } rowCmd_e;

  typedef enum logic [1:0] {
    MM_NONE    = 2'd0,
    MM_CYCLE   = 2'd1,
    MM_PERSIST = 2'd2
  } maskMode_e;

  typedef struct packed {
    logic      loadColor;
    logic      loadMask;
    logic      latchMask;
    logic      doBlock;
    maskMode_e mode;
  } ctlStrb_t;

endpackage

// File: rtl/blkw_insync.sv
module blkw_insync
  import blkw_pkg::*;
#(
  parameter int ROW_W  = 1,
  parameter int GRP_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStrobeN,
  input  logic              colStrobeN,
  input  logic              writeEnN,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [GRP_W-1:0]  colGrp,
  output logic              rowFall,
  output logic              rowRise,
  output logic              colFall,
  output logic              colLow,
  output logic              weLow,
  output rowCmd_e           cmdS,
  output logic [DATA_W-1:0] dataS,
  output logic [ROW_W-1:0]  rowAddrS,
  output logic [GRP_W-1:0]  colGrpS
);

  logic rowQ, rowQd, colQ, colQd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= 1'b1;
      rowQd    <= 1'b1;
      colQ     <= 1'b1;
      colQd    <= 1'b1;
      weLow    <= 1'b0;
      cmdS     <= CMD_NOP;
      dataS    <= '0;
      rowAddrS <= '0;
      colGrpS  <= '0;
    end else begin
      rowQ     <= rowStrobeN;
      rowQd    <= rowQ;
      colQ     <= colStrobeN;
      colQd    <= colQ;
      weLow    <= ~writeEnN;
      cmdS     <= rowCmd_e'(cmd);
      dataS    <= dataIn;
      rowAddrS <= rowAddr;
      colGrpS  <= colGrp;
    end
  end

  assign rowFall = rowQd & ~rowQ;
  assign rowRise = ~rowQd & rowQ;
  assign colFall = colQd & ~colQ;
  assign colLow  = ~colQ;

endmodule

// File: rtl/blkw_ctl.sv
module blkw_ctl
  import blkw_pkg::*;
#(
  parameter int ROW_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rowFall,
  input  logic             rowRise,
  input  logic             colFall,
  input  logic             colLow,
  input  logic             weLow,
  input  rowCmd_e          cmdS,
  input  logic [ROW_W-1:0] rowAddrS,
  output ctlStrb_t         strb,
  output logic [ROW_W-1:0] rowSel
);

  logic      rowActive;
  rowCmd_e   rowCmdQ;
  maskMode_e modeQ;
  logic      persistFlag;
  logic      refreshEv;
  logic      normalFall;

  assign refreshEv  = rowFall & colLow;
  assign normalFall = rowFall & ~colLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowActive   <= 1'b0;
      rowCmdQ     <= CMD_NOP;
      modeQ       <= MM_NONE;
      persistFlag <= 1'b0;
      rowSel      <= '0;
    end else if (rowFall) begin
      rowActive <= 1'b1;
      rowSel    <= rowAddrS;
      if (refreshEv) begin
        rowCmdQ     <= CMD_NOP;
        modeQ       <= MM_NONE;
        persistFlag <= 1'b0;
      end else begin
        rowCmdQ <= cmdS;
        if (!weLow)           modeQ <= MM_NONE;
        else if (persistFlag) modeQ <= MM_PERSIST;
        else                  modeQ <= MM_CYCLE;
        if (cmdS == CMD_LDMASK) persistFlag <= 1'b1;
      end
    end else if (rowRise) begin
      rowActive <= 1'b0;
    end
  end

  always_comb begin
    strb.loadColor = normalFall && (cmdS == CMD_LDCOLOR);
    strb.loadMask  = normalFall && (cmdS == CMD_LDMASK);
    strb.latchMask = normalFall && (cmdS == CMD_BLOCK) && weLow && !persistFlag;
    strb.doBlock   = colFall && rowActive && (rowCmdQ == CMD_BLOCK);
    strb.mode      = modeQ;
  end

  // R3: write-enable high at a normal row fall leaves the cycle unmasked
  a_r3_we_high_no_mask: assert property (@(posedge clk) disable iff (!rstN)
    (normalFall && !weLow) |=> (modeQ == MM_NONE));

  // R5: with the sticky flag set, a masked row cycle uses the register
  a_r5_persist_select: assert property (@(posedge clk) disable iff (!rstN)
    (normalFall && weLow && persistFlag) |=> (modeQ == MM_PERSIST));

  // R6: refresh drops the sticky flag
  a_r6_refresh_clears: assert property (@(posedge clk) disable iff (!rstN)
    refreshEv |=> !persistFlag);

  // R10: the selected row only moves at a row-strobe fall
  a_r10_row_held: assert property (@(posedge clk) disable iff (!rstN)
    !rowFall |=> $stable(rowSel));

endmodule

// File: rtl/blkw_dp.sv
module blkw_dp
  import blkw_pkg::*;
#(
  parameter int ROW_W  = 1,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int BLK    = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrb_t                strb,
  input  logic [DATA_W-1:0]       dataS,
  input  logic [ROW_W-1:0]        rowSel,
  input  logic [COL_W-$clog2(BLK)-1:0] colGrpS,
  input  logic [ROW_W-1:0]        rdRow,
  input  logic [COL_W-1:0]        rdCol,
  output logic [DATA_W-1:0]       rdData
);

  localparam int BLK_W     = $clog2(BLK);
  localparam int BYTES     = DATA_W / 8;
  localparam int MEM_AW    = ROW_W + COL_W;
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] colorReg;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] cycMask;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [MEM_AW-1:0] colIdx [BLK];
  logic [DATA_W-1:0] colNew [BLK];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colorReg <= '0;
      maskReg  <= '0;
      cycMask  <= '0;
    end else begin
      if (strb.loadColor) colorReg <= dataS;
      if (strb.loadMask)  maskReg  <= dataS;
      if (strb.latchMask) cycMask  <= dataS;
    end
  end

  always_comb begin
    case (strb.mode)
      MM_CYCLE:   bitMask = cycMask;
      MM_PERSIST: bitMask = maskReg;
      default:    bitMask = '1;
    endcase
  end

  for (genvar gi = 0; gi < BLK; gi++) begin : g_col
    logic [DATA_W-1:0] laneEn;
    logic [DATA_W-1:0] wrMask;
    always_comb begin
      for (int b = 0; b < BYTES; b++) begin
        laneEn[b*8 +: 8] = {8{dataS[b*BLK + gi]}};
      end
    end
    assign wrMask     = laneEn & bitMask;
    assign colIdx[gi] = {rowSel, colGrpS, BLK_W'(gi)};
    assign colNew[gi] = (mem[colIdx[gi]] & ~wrMask) | (colorReg & wrMask);
  end

  always_ff @(posedge clk) begin
    if (strb.doBlock) begin
      for (int i = 0; i < BLK; i++) begin
        mem[colIdx[i]] <= colNew[i];
      end
    end
  end

  assign rdData = mem[{rdRow, rdCol}];

  // R2: colour register moves only on a load-colour command
  a_r2_color_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadColor |=> $stable(colorReg));

  // R5: mask register moves only on a load-mask command
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadMask |=> $stable(maskReg));

  // R4: the per-cycle mask is captured only at a qualifying row fall
  a_r4_cycle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchMask |=> $stable(cycMask));

endmodule

// File: rtl/blkw_top.sv
module blkw_top
  import blkw_pkg::*;
#(
  parameter int ROW_W  = 1,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16,
  parameter int BLK    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStrobeN,
  input  logic              colStrobeN,
  input  logic              writeEnN,
  input  logic [1:0]        cmd,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [ROW_W-1:0]  rowAddr,
  input  logic [COL_W-1:0]  colAddr,
  input  logic [ROW_W-1:0]  rdRow,
  input  logic [COL_W-1:0]  rdCol,
  output logic [DATA_W-1:0] rdData
);

  localparam int BLK_W = $clog2(BLK);
  localparam int GRP_W = COL_W - BLK_W;

  logic              rowFall, rowRise, colFall, colLow, weLow;
  rowCmd_e           cmdS;
  logic [DATA_W-1:0] dataS;
  logic [ROW_W-1:0]  rowAddrS;
  logic [GRP_W-1:0]  colGrpS;
  logic [ROW_W-1:0]  rowSel;
  ctlStrb_t          strb;
  logic              unusedColLow;

  assign unusedColLow = ^colAddr[BLK_W-1:0];

  blkw_insync #(.ROW_W(ROW_W), .GRP_W(GRP_W), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rstN(rstN),
    .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN), .writeEnN(writeEnN),
    .cmd(cmd), .dataIn(dataIn), .rowAddr(rowAddr),
    .colGrp(colAddr[COL_W-1:BLK_W]),
    .rowFall(rowFall), .rowRise(rowRise), .colFall(colFall), .colLow(colLow),
    .weLow(weLow), .cmdS(cmdS), .dataS(dataS), .rowAddrS(rowAddrS),
    .colGrpS(colGrpS)
  );

  blkw_ctl #(.ROW_W(ROW_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .rowFall(rowFall), .rowRise(rowRise), .colFall(colFall), .colLow(colLow),
    .weLow(weLow), .cmdS(cmdS), .rowAddrS(rowAddrS),
    .strb(strb), .rowSel(rowSel)
  );

  blkw_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BLK(BLK)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dataS(dataS),
    .rowSel(rowSel), .colGrpS(colGrpS),
    .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );

endmodule

// File: tb/blkw_top_tb.sv
module blkw_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rowStrobeN = 1'b1;
  logic        colStrobeN = 1'b1;
  logic        writeEnN = 1'b1;
  logic [1:0]  cmd = 2'b11;
  logic [15:0] dataIn = '0;
  logic [0:0]  rowAddr = '0;
  logic [8:0]  colAddr = '0;
  logic [0:0]  rdRow = '0;
  logic [8:0]  rdCol = '0;
  logic [15:0] rdData;

  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;
  logic [15:0] shadow [2][512];
  logic [15:0] expColor = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkw_top u_dut (
    .clk(clk), .rstN(rstN), .rowStrobeN(rowStrobeN), .colStrobeN(colStrobeN),
    .writeEnN(writeEnN), .cmd(cmd), .dataIn(dataIn), .rowAddr(rowAddr),
    .colAddr(colAddr), .rdRow(rdRow), .rdCol(rdCol), .rdData(rdData)
  );

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rowOpen(logic [1:0] c, logic weN, logic [15:0] d, int row);
    @(negedge clk);
    cmd = c; writeEnN = weN; dataIn = d; rowAddr = 1'(row); rowStrobeN = 1'b0;
    settle();
    writeEnN = 1'b1; cmd = 2'b11;
  endtask

  task automatic rowClose();
    @(negedge clk);
    rowStrobeN = 1'b1;
    settle();
  endtask

  task automatic colPulse(int addr, logic [15:0] en);
    @(negedge clk);
    colAddr = 9'(addr); dataIn = en; colStrobeN = 1'b0;
    settle();
    colStrobeN = 1'b1;
    settle();
  endtask

  task automatic loadColor(logic [15:0] v);
    rowOpen(2'b01, 1'b1, v, 0);
    rowClose();
    expColor = v;
  endtask

  task automatic loadMask(logic [15:0] v);
    rowOpen(2'b10, 1'b1, v, 0);
    rowClose();
  endtask

  task automatic refreshCycle();
    @(negedge clk); colStrobeN = 1'b0; settle();
    rowStrobeN = 1'b0; settle();
    rowStrobeN = 1'b1; settle();
    colStrobeN = 1'b1; settle();
  endtask

  task automatic modelBlock(int row, int addr, logic [15:0] en, logic [15:0] bm);
    int base = (addr / 8) * 8;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] m = {{8{en[8+i]}}, {8{en[i]}}} & bm;
      shadow[row][base+i] = (shadow[row][base+i] & ~m) | (expColor & m);
    end
  endtask

  task automatic checkCols(int row, int first, int n, string req);
    for (int c = first; c < first + n; c++) begin
      rdRow = 1'(row); rdCol = 9'(c);
      #1;
      nChecks++;
      if (rdData !== shadow[row][c]) begin
        nFails++;
        $display("FAIL %s row %0d col %0d actual %h expected %h",
                 req, row, c, rdData, shadow[row][c]);
      end
    end
  endtask

  // R1, R11: after reset the colour is zero; fill both rows unmasked
  task automatic t_reset();
    rowOpen(2'b00, 1'b1, 16'hFFFF, 0);
    for (int g = 0; g < 4; g++) begin
      colPulse(g*8, 16'hFFFF);
      modelBlock(0, g*8, 16'hFFFF, 16'hFFFF);
    end
    rowClose();
    rowOpen(2'b00, 1'b1, 16'hFFFF, 1);
    for (int g = 0; g < 2; g++) begin
      colPulse(g*8, 16'hFFFF);
      modelBlock(1, g*8, 16'hFFFF, 16'hFFFF);
    end
    rowClose();
    checkCols(0, 0, 32, "R1");
    checkCols(1, 0, 16, "R11");
  endtask

  // R2, R3: load colour, non-block row writes nothing, unmasked write
  task automatic t_color();
    rowOpen(2'b01, 1'b1, 16'hA5C3, 0);
    colPulse(0, 16'hFFFF);
    rowClose();
    expColor = 16'hA5C3;
    checkCols(0, 0, 8, "R2");
    rowOpen(2'b00, 1'b1, 16'h0000, 0);
    colPulse(8, 16'hFFFF);
    modelBlock(0, 8, 16'hFFFF, 16'hFFFF);
    rowClose();
    checkCols(0, 8, 8, "R3");
  endtask

  // R7, R8: unaligned address and a sparse byte-enable map
  task automatic t_enables();
    loadColor(16'h1234);
    rowOpen(2'b00, 1'b1, 16'h0000, 0);
    colPulse(21, 16'h5A81);
    modelBlock(0, 21, 16'h5A81, 16'hFFFF);
    rowClose();
    checkCols(0, 16, 8, "R8");
    checkCols(0, 24, 8, "R7");
  endtask

  // R4: per-cycle latched mask, renewed on each masked row cycle
  task automatic t_cycleMask();
    loadColor(16'hFFFF);
    rowOpen(2'b00, 1'b0, 16'h0F0F, 0);
    colPulse(0, 16'hFFFF);
    modelBlock(0, 0, 16'hFFFF, 16'h0F0F);
    rowClose();
    checkCols(0, 0, 8, "R4");
    loadColor(16'h0000);
    rowOpen(2'b00, 1'b0, 16'h0300, 0);
    colPulse(0, 16'hFFFF);
    modelBlock(0, 0, 16'hFFFF, 16'h0300);
    rowClose();
    checkCols(0, 0, 8, "R4");
  endtask

  // R9, R10: two page cycles in one row; row input moves mid-cycle
  task automatic t_pages();
    loadColor(16'hBEEF);
    rowOpen(2'b00, 1'b1, 16'h0000, 1);
    colPulse(0, 16'h00FF);
    modelBlock(1, 0, 16'h00FF, 16'hFFFF);
    @(negedge clk); rowAddr = 1'b0;
    colPulse(9, 16'hFF00);
    modelBlock(1, 9, 16'hFF00, 16'hFFFF);
    rowClose();
    checkCols(1, 0, 16, "R9");
    checkCols(0, 0, 16, "R10");
  endtask

  // R5: sticky mask register overrides the data bus at row fall
  task automatic t_persist();
    loadMask(16'h00FF);
    loadColor(16'hFFFF);
    rowOpen(2'b00, 1'b0, 16'hFF00, 0);
    colPulse(24, 16'hFFFF);
    modelBlock(0, 24, 16'hFFFF, 16'h00FF);
    rowClose();
    checkCols(0, 24, 8, "R5");
    loadColor(16'h0000);
    rowOpen(2'b00, 1'b0, 16'hFFFF, 0);
    colPulse(24, 16'hFFFF);
    modelBlock(0, 24, 16'hFFFF, 16'h00FF);
    rowClose();
    checkCols(0, 24, 8, "R5");
  endtask

  // R6: refresh drops the sticky mask; bus is latched again
  task automatic t_refresh();
    refreshCycle();
    checkCols(0, 0, 32, "R6");
    loadColor(16'hFFFF);
    rowOpen(2'b00, 1'b0, 16'hF000, 0);
    colPulse(24, 16'hFFFF);
    modelBlock(0, 24, 16'hFFFF, 16'hF000);
    rowClose();
    checkCols(0, 24, 8, "R6");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual hung expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_color();
    t_enables();
    t_cycleMask();
    t_pages();
    t_persist();
    t_refresh();
    finishRun();
  end

endmodule